// File: doc/BRIEF.md
# Converter Fault Timing and Shutdown Controller

This block sits between the qualified comparator outputs of several switching converter channels and the rest of a power-management chip. For each channel it watches three inputs: a current-limit flag, an output-below-threshold flag and an output-at-target flag. It also watches two die-temperature inputs, one for a warning level and one for shutdown. It times these inputs in clock cycles and sends one-cycle event pulses to the interrupt logic. It also drives a per-channel enable gate that switches a converter off when that converter faults, and switches all converters off when the die overheats.

The clock frequency is a parameter. The microsecond and millisecond windows are converted from it into cycle counts: `ILIM_CYC` for the current-limit debounce and `CHECK_CYC` for the start-up check and the overload debounce.

Each channel runs its own state machine with five states:
- `CH_OFF`: idle.
- `CH_CHECK`: the post-enable window is running.
- `CH_RUN`: normal operation.
- `CH_FAULT`: latched off after a short circuit or an overload.
- `CH_THERM`: held off by thermal shutdown.

The transitions are:
- OFF→CHECK when the request is high and there is no thermal shutdown.
- CHECK→RUN when the low flag is clear at the end of the window.
- CHECK→FAULT when the low flag is set at the end of the window (short circuit).
- RUN→FAULT when the overload debounce completes.
- CHECK/RUN→OFF when the request drops.
- FAULT→OFF when the request drops.
- Any of CHECK, RUN or FAULT →THERM when shutdown is asserted.
- THERM→OFF once both shutdown and the request are low.

Top module: `conv_fault_ctrl`

## Requirements
- R1: While a channel is enabled, `ilim_in` held high for `ILIM_CYC` consecutive cycles gives exactly one `ilim_evt` pulse for that channel, in the cycle after the `ILIM_CYC`-th high sample. The channel stays enabled.
- R2: If a debounced input (current limit, or output-low during RUN) drops before its count completes, the count restarts from zero.
- R3: After a request is accepted, `conv_en` is high for exactly `CHECK_CYC` cycles. If `uv_in` is high at the last of them, the channel turns off in the next cycle and `sc_evt` pulses for one cycle.
- R4: If `uv_in` is low at the end of the check window, the channel stays enabled (enters RUN) and no `sc_evt` is raised.
- R5: In RUN, `uv_in` high for `CHECK_CYC` consecutive cycles turns the channel off and raises a one-cycle `sc_evt` pulse.
- R6: A channel turned off by R3 or R5 stays off while `en_req` stays high. It re-enables only after `en_req` goes low and then high again. Other channels are not affected.
- R7: `tsd_in` high at a clock edge forces every `conv_en` bit low in the next cycle. `tsd_evt` pulses for one cycle on a rising edge of `tsd_in`.
- R8: After thermal shutdown a channel restarts only once `tsd_in` is low and its `en_req` has been low and has then risen again. A request toggled while `tsd_in` is still high does not restart it.
- R9: `tw_evt` pulses for one cycle on a rising edge of `tw_in` and does not change any enable.
- R10: `pg_evt` for a channel pulses for one cycle on a rising edge of that channel's `pg_in` while the channel is enabled, not on every cycle the input is high.
- R11: Dropping `en_req` of an enabled channel turns that channel off in the next cycle.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | N_CH | Per-channel enable request |
| ilim_in | input | N_CH | Current-limit comparator flag |
| uv_in | input | N_CH | Output-below-threshold comparator flag |
| pg_in | input | N_CH | Output-at-target comparator flag |
| tw_in | input | 1 | Die temperature warning flag |
| tsd_in | input | 1 | Die temperature shutdown flag |
| conv_en | output | N_CH | Per-channel converter enable gate |
| ilim_evt | output | N_CH | Current-limit event pulse |
| sc_evt | output | N_CH | Short-circuit / overload event pulse |
| pg_evt | output | N_CH | Power-good event pulse |
| tw_evt | output | 1 | Thermal warning event pulse |
| tsd_evt | output | 1 | Thermal shutdown event pulse |

## Verification
The assertions check on every cycle the properties that depend only on the state in neighbouring cycles:
- thermal shutdown forcing all enables low;
- an enable rising only after an accepted request;
- a dropped request turning its channel off;
- a fault pulse never coinciding with an enabled channel;
- every event being a single-cycle pulse.

The exact window lengths can only be shown by the bench scenarios, which it runs on every channel:
- the start-up check at its last cycle;
- the overload and current-limit debounce counts, including their restart;
- the latch-off until the request is toggled;
- the restart rules after thermal shutdown.

// File: rtl/conv_fault_pkg.sv
package conv_fault_pkg;

    typedef enum logic [2:0] {
        CH_OFF   = 3'd0,
        CH_CHECK = 3'd1,
        CH_RUN   = 3'd2,
        CH_FAULT = 3'd3,
        CH_THERM = 3'd4
    } ch_state_e;

    function automatic int unsigned us_to_cyc(input int unsigned clk_hz, input int unsigned us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/fault_debounce.sv
module fault_debounce #(
    parameter int unsigned CNT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic trip
);
    localparam int unsigned CW = $clog2(CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(CNT - 1);
    localparam logic [CW-1:0] FULL = CW'(CNT);

    logic [CW-1:0] cnt_q;

    // trip is high at the edge that takes the CNT-th consecutive high sample
    assign trip = en && din && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!(en && din)) begin
            cnt_q <= '0;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    assign rise = din && !prev_q;
endmodule

// File: rtl/conv_chan_fsm.sv
module conv_chan_fsm
    import conv_fault_pkg::*;
#(
    parameter int unsigned ILIM_CYC  = 20,
    parameter int unsigned CHECK_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic tsd,
    input  logic ilim,
    input  logic uv,
    input  logic pg,
    output logic conv_en,
    output logic ilim_evt,
    output logic sc_evt,
    output logic pg_evt
);
    localparam int unsigned WW = $clog2(CHECK_CYC);
    localparam logic [WW-1:0] WIN_LAST = WW'(CHECK_CYC - 1);

    ch_state_e     state_q, state_d;
    logic [WW-1:0] win_q;
    logic          win_last;
    logic          ov_trip, ilim_trip, pg_rise;
    logic          sc_d;

    assign win_last = (win_q == WIN_LAST);
    assign conv_en  = (state_q == CH_CHECK) || (state_q == CH_RUN);

    fault_debounce #(.CNT(ILIM_CYC)) u_ilim_db (
        .clk (clk), .rst_n (rst_n), .en (conv_en), .din (ilim), .trip (ilim_trip)
    );

    fault_debounce #(.CNT(CHECK_CYC)) u_ov_db (
        .clk (clk), .rst_n (rst_n), .en (state_q == CH_RUN), .din (uv), .trip (ov_trip)
    );

    rise_detect u_pg_edge (
        .clk (clk), .rst_n (rst_n), .din (pg), .rise (pg_rise)
    );

    // post-enable check window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    win_q <= '0;
        else if (state_q != CH_CHECK)  win_q <= '0;
        else                           win_q <= win_q + 1'b1;
    end

    // next state and fault decision
    always_comb begin
        state_d = state_q;
        sc_d    = 1'b0;
        unique case (state_q)
            CH_OFF: begin
                if (en_req && !tsd) state_d = CH_CHECK;
            end
            CH_CHECK: begin
                if (tsd)              state_d = CH_THERM;
                else if (!en_req)     state_d = CH_OFF;
                else if (win_last) begin
                    if (uv) begin
                        state_d = CH_FAULT;
                        sc_d    = 1'b1;
                    end else begin
                        state_d = CH_RUN;
                    end
                end
            end
            CH_RUN: begin
                if (tsd)              state_d = CH_THERM;
                else if (!en_req)     state_d = CH_OFF;
                else if (ov_trip) begin
                    state_d = CH_FAULT;
                    sc_d    = 1'b1;
                end
            end
            CH_FAULT: begin
                if (tsd)              state_d = CH_THERM;
                else if (!en_req)     state_d = CH_OFF;
            end
            CH_THERM: begin
                if (!tsd && !en_req)  state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilim_evt <= 1'b0;
            sc_evt   <= 1'b0;
            pg_evt   <= 1'b0;
        end else begin
            ilim_evt <= ilim_trip;
            sc_evt   <= sc_d;
            pg_evt   <= pg_rise && conv_en;
        end
    end
endmodule

// File: rtl/conv_fault_ctrl.sv
module conv_fault_ctrl
    import conv_fault_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned N_CH     = 4,
    parameter int unsigned ILIM_US  = 20,
    parameter int unsigned CHECK_US = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] en_req,
    input  logic [N_CH-1:0] ilim_in,
    input  logic [N_CH-1:0] uv_in,
    input  logic [N_CH-1:0] pg_in,
    input  logic            tw_in,
    input  logic            tsd_in,
    output logic [N_CH-1:0] conv_en,
    output logic [N_CH-1:0] ilim_evt,
    output logic [N_CH-1:0] sc_evt,
    output logic [N_CH-1:0] pg_evt,
    output logic            tw_evt,
    output logic            tsd_evt
);
    localparam int unsigned ILIM_CYC  = us_to_cyc(CLK_HZ, ILIM_US);
    localparam int unsigned CHECK_CYC = us_to_cyc(CLK_HZ, CHECK_US);

    logic tw_rise, tsd_rise;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        conv_chan_fsm #(.ILIM_CYC(ILIM_CYC), .CHECK_CYC(CHECK_CYC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_req   (en_req[g]),
            .tsd      (tsd_in),
            .ilim     (ilim_in[g]),
            .uv       (uv_in[g]),
            .pg       (pg_in[g]),
            .conv_en  (conv_en[g]),
            .ilim_evt (ilim_evt[g]),
            .sc_evt   (sc_evt[g]),
            .pg_evt   (pg_evt[g])
        );
    end

    rise_detect u_tw_edge  (.clk (clk), .rst_n (rst_n), .din (tw_in),  .rise (tw_rise));
    rise_detect u_tsd_edge (.clk (clk), .rst_n (rst_n), .din (tsd_in), .rise (tsd_rise));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_evt  <= 1'b0;
            tsd_evt <= 1'b0;
        end else begin
            tw_evt  <= tw_rise;
            tsd_evt <= tsd_rise;
        end
    end
endmodule

// File: rtl/conv_fault_ctrl_chk.sv
module conv_fault_ctrl_chk #(
    parameter int unsigned N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] en_req,
    input logic            tsd_in,
    input logic [N_CH-1:0] conv_en,
    input logic [N_CH-1:0] sc_evt,
    input logic [N_CH-1:0] pg_evt,
    input logic            tw_evt,
    input logic            tsd_evt
);
    // R7
    tsd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_in |=> (conv_en == '0));

    // R7
    tsd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_evt |=> !tsd_evt);

    // R9
    tw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_evt |=> !tw_evt);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R8
        en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(conv_en[g]) |-> ($past(en_req[g]) && !$past(tsd_in)));

        // R11
        req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_en[g] && !en_req[g]) |=> !conv_en[g]);

        // R3
        sc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sc_evt[g] |-> !conv_en[g]);

        // R5
        sc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sc_evt[g] |=> !sc_evt[g]);

        // R10
        pg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pg_evt[g] |=> !pg_evt[g]);
    end
endmodule

bind conv_fault_ctrl conv_fault_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_req  (en_req),
    .tsd_in  (tsd_in),
    .conv_en (conv_en),
    .sc_evt  (sc_evt),
    .pg_evt  (pg_evt),
    .tw_evt  (tw_evt),
    .tsd_evt (tsd_evt)
);

// File: tb/conv_fault_ctrl_bench.sv
module conv_fault_ctrl_bench;
    localparam int N     = 4;
    localparam int ILIM  = 20;
    localparam int CHECK = 1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] en_req = '0, ilim_in = '0, uv_in = '0, pg_in = '0;
    logic         tw_in = 1'b0, tsd_in = 1'b0;
    logic [N-1:0] conv_en, ilim_evt, sc_evt, pg_evt;
    logic         tw_evt, tsd_evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    conv_fault_ctrl #(.CLK_HZ(1_000_000), .N_CH(N), .ILIM_US(ILIM), .CHECK_US(CHECK)) u_conv_fault_ctrl (
        .clk (clk), .rst_n (rst_n), .en_req (en_req), .ilim_in (ilim_in),
        .uv_in (uv_in), .pg_in (pg_in), .tw_in (tw_in), .tsd_in (tsd_in),
        .conv_en (conv_en), .ilim_evt (ilim_evt), .sc_evt (sc_evt),
        .pg_evt (pg_evt), .tw_evt (tw_evt), .tsd_evt (tsd_evt)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R12 reset state
        chk("R12 outputs in reset", {conv_en, ilim_evt, sc_evt, pg_evt, tw_evt, tsd_evt}, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R12 outputs after reset", {conv_en, ilim_evt, sc_evt, pg_evt, tw_evt, tsd_evt}, 0);

        for (int c = 0; c < N; c++) begin
            // R3 short circuit at end of check window
            uv_in[c] = 1'b1; en_req[c] = 1'b1;
            tick(1);
            chk("R3 enable accepted", conv_en, 1 << c);
            tick(CHECK - 1);
            chk("R3 on at last window cycle", conv_en, 1 << c);
            chk("R3 no early sc_evt", sc_evt, 0);
            tick(1);
            chk("R3 off after short", conv_en, 0);
            chk("R3 sc_evt pulse", sc_evt, 1 << c);
            tick(1);
            chk("R3 sc_evt one cycle", sc_evt, 0);
            // R6 latched off while request stays high
            uv_in[c] = 1'b0;
            tick(5);
            chk("R6 stays off", conv_en, 0);
            en_req[c] = 1'b0; tick(1);
            en_req[c] = 1'b1; tick(1);
            chk("R6 re-enable after toggle", conv_en, 1 << c);
            // R4 clean start
            tick(CHECK);
            chk("R4 running after window", conv_en, 1 << c);
            chk("R4 no sc_evt", sc_evt, 0);
            // R1 current limit
            ilim_in[c] = 1'b1;
            tick(ILIM - 1);
            chk("R1 no early ilim_evt", ilim_evt, 0);
            tick(1);
            chk("R1 ilim_evt pulse", ilim_evt, 1 << c);
            chk("R1 converter still on", conv_en, 1 << c);
            tick(1);
            chk("R1 ilim_evt single", ilim_evt, 0);
            ilim_in[c] = 1'b0; tick(1);
            // R2 restart of current-limit debounce
            ilim_in[c] = 1'b1; tick(ILIM - 1);
            ilim_in[c] = 1'b0; tick(1);
            chk("R2 no ilim_evt on short pulse", ilim_evt, 0);
            ilim_in[c] = 1'b1; tick(ILIM - 1);
            chk("R2 count restarted", ilim_evt, 0);
            tick(1);
            chk("R2 ilim_evt after full count", ilim_evt, 1 << c);
            ilim_in[c] = 1'b0; tick(1);
            // R10 power good edge
            pg_in[c] = 1'b1; tick(1);
            chk("R10 pg_evt on rise", pg_evt, 1 << c);
            tick(1);
            chk("R10 pg_evt single", pg_evt, 0);
            pg_in[c] = 1'b0;
            // R5 / R2 overload debounce
            uv_in[c] = 1'b1; tick(CHECK - 1);
            uv_in[c] = 1'b0; tick(1);
            chk("R2 overload restart keeps on", conv_en, 1 << c);
            uv_in[c] = 1'b1; tick(CHECK - 1);
            chk("R5 on before full count", conv_en, 1 << c);
            tick(1);
            chk("R5 off after overload", conv_en, 0);
            chk("R5 sc_evt pulse", sc_evt, 1 << c);
            uv_in[c] = 1'b0; en_req[c] = 1'b0; tick(1);
        end

        // all channels running
        en_req = '1; tick(CHECK + 2);
        chk("R4 all running", conv_en, 4'hF);
        // R6 one channel faults, others unaffected
        uv_in[0] = 1'b1; tick(CHECK);
        chk("R6 others unaffected", conv_en, 4'hE);
        uv_in[0] = 1'b0;
        // R9 warning
        tw_in = 1'b1; tick(1);
        chk("R9 tw_evt pulse", tw_evt, 1);
        chk("R9 enables unchanged", conv_en, 4'hE);
        tick(1);
        chk("R9 tw_evt single", tw_evt, 0);
        tw_in = 1'b0;
        // R7 shutdown
        tsd_in = 1'b1; tick(1);
        chk("R7 all off", conv_en, 0);
        chk("R7 tsd_evt pulse", tsd_evt, 1);
        tick(1);
        chk("R7 tsd_evt single", tsd_evt, 0);
        // R8 toggle while shutdown high
        en_req = '0; tick(1);
        en_req = '1; tick(2);
        chk("R8 no restart during shutdown", conv_en, 0);
        tsd_in = 1'b0; tick(3);
        chk("R8 no restart without new request", conv_en, 0);
        en_req = '0; tick(1);
        en_req = '1; tick(1);
        chk("R8 restart after new request", conv_en, 4'hF);
        // R11 request drop
        en_req[2] = 1'b0; tick(1);
        chk("R11 drop turns off", conv_en, 4'hB);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule